// File: doc/BRIEF.md
# VME A24 Slave Window Controller

This block lets other bus masters reach the local DRAM through a 4 MB window placed in the 24-bit address space of a VMEbus backplane. It synchronizes the address strobe and both data strobes, samples the address, address modifier, long-word and write lines at the start of each data phase, and decides whether to answer. An accepted access becomes a request to the DRAM controller. The acknowledge is raised when that request completes. An access that falls in the window but past the end of the fitted DRAM gets a bus error instead. Accesses the block does not support get no reply at all, so the bus timer can end them.

Each slave write that the DRAM controller accepts produces a single-cycle cache-invalidate strobe that carries the word address written. A slave read is treated as the possible first half of an indivisible read-modify-write. From the moment the read is accepted, a hold output stalls the local processor's DRAM requests. The hold stays on until the write that ends the sequence has had its data strobes released, or until the address strobe is released. A master that only reads therefore cannot lock the processor out.

Top module: `vme_a24_win_ctl`

## Requirements
- R1: After reset, vme_dtack_n and vme_berr_n are high, and dram_req, inv_valid and cpu_hold are low.
- R2: While slave_en is low, no access produces dram_req, DTACK or BERR.
- R3: An access is decoded only when address bits A23..A22 equal win_base. Any other address is ignored.
- R4: Only address modifier codes 0x39, 0x3A, 0x3D and 0x3E are answered. Block-transfer codes 0x3B and 0x3F, and every other code, are ignored.
- R5: Single-byte (one data strobe) and 16-bit (both data strobes) accesses with vme_lword_n high are served, and dram_be equals {DS1 asserted, DS0 asserted}. An access with vme_lword_n low is ignored.
- R6: A served access holds dram_req high until dram_ack. dram_we is 1 for a write. dram_addr is address bits A21..A1. vme_dtack_n goes low after dram_ack and is never low together with vme_berr_n.
- R7: A decoded access whose offset has bit A21 set (beyond the DRAM) drives vme_berr_n low and issues no dram_req.
- R8: vme_dtack_n and vme_berr_n return high within four clocks of both data strobes negating.
- R9: A served write produces exactly one cycle of inv_valid in the clock after dram_ack, with inv_addr equal to dram_addr. Reads and BERR cycles produce none.
- R10: cpu_hold rises when a slave read is accepted and stays high while the address strobe remains asserted. cpu_go equals cpu_req while cpu_hold is low and is 0 while cpu_hold is high.
- R11: Under a held address strobe, cpu_hold clears within four clocks after the data strobes of the terminating write negate.
- R12: cpu_hold clears within four clocks of the address strobe negating, even if no write followed the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_en | input | 1 | Slave response enable |
| win_base | input | 2 | Window selector compared with A23..A22 |
| vme_addr | input | 23 | Bus address A23..A1 |
| vme_am | input | 6 | Address modifier |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds0_n | input | 1 | Data strobe for the odd byte, active low |
| vme_ds1_n | input | 1 | Data strobe for the even byte, active low |
| vme_lword_n | input | 1 | Long-word select, active low |
| vme_write_n | input | 1 | Low for a write |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| vme_berr_n | output | 1 | Bus error, active low |
| dram_req | output | 1 | DRAM access request |
| dram_we | output | 1 | DRAM write select |
| dram_addr | output | 21 | DRAM word address |
| dram_be | output | 2 | Byte lanes {even, odd} |
| dram_ack | input | 1 | DRAM access complete |
| inv_valid | output | 1 | Cache-invalidate strobe |
| inv_addr | output | 21 | Word address to invalidate |
| cpu_req | input | 1 | Local processor DRAM request |
| cpu_go | output | 1 | Processor request may proceed |
| cpu_hold | output | 1 | Read-modify-write lock active |

## Verification
The bench uses the default parameters: a 22-bit window in a 24-bit space, with DRAM covering the lower half of the window. This makes both the served half and the bus-error half of one window reachable with plain addresses. win_base is set to 1, so addresses below 0x400000 exercise the miss case. Two synchronizer stages set the response and release latencies that the bench polls against. These runs include a held address strobe closed by a write, and a held address strobe released without any write.

// File: rtl/vme_win_pkg.sv
package vme_win_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_BERR,
    ST_SKIP
  } slv_state_e;

  typedef enum logic [1:0] {
    DEC_NONE,
    DEC_DRAM,
    DEC_BERR
  } dec_kind_e;

  localparam logic [5:0] AM_USR_DATA = 6'h39;
  localparam logic [5:0] AM_USR_PROG = 6'h3A;
  localparam logic [5:0] AM_SUP_DATA = 6'h3D;
  localparam logic [5:0] AM_SUP_PROG = 6'h3E;

  function automatic logic am_accepted(input logic [5:0] am);
    return (am == AM_USR_DATA) || (am == AM_USR_PROG) ||
           (am == AM_SUP_DATA) || (am == AM_SUP_PROG);
  endfunction

endpackage

// File: rtl/vme_sync.sv
module vme_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stg_d[i] = d;
      end else begin : g_next
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/vme_decode.sv
module vme_decode
  import vme_win_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int WIN_W   = 22,
  parameter int DRAM_AW = 21
) (
  input  logic [ADDR_W-1:1]      addr,
  input  logic [ADDR_W-WIN_W-1:0] win_base,
  input  logic [5:0]             am,
  input  logic                   lword_n,
  input  logic [1:0]             ds_act,
  input  logic                   slave_en,
  output dec_kind_e              kind,
  output logic [WIN_W-1:1]       offs
);

  logic in_win;
  logic size_ok;
  logic accept;
  logic beyond;

  assign in_win  = (addr[ADDR_W-1:WIN_W] == win_base);
  assign size_ok = (|ds_act) && lword_n;
  assign accept  = slave_en && in_win && am_accepted(am) && size_ok;
  assign offs    = addr[WIN_W-1:1];

  generate
    if (DRAM_AW < WIN_W) begin : g_partial
      assign beyond = |addr[WIN_W-1:DRAM_AW];
    end else begin : g_full
      assign beyond = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!accept) begin
      kind = DEC_NONE;
    end else if (beyond) begin
      kind = DEC_BERR;
    end else begin
      kind = DEC_DRAM;
    end
  end

endmodule

// File: rtl/vme_slave_fsm.sv
module vme_slave_fsm
  import vme_win_pkg::*;
#(
  parameter int OFF_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             as_act,
  input  logic [1:0]       ds_act,
  input  dec_kind_e        kind,
  input  logic [OFF_W-1:0] offs,
  input  logic             write_n,
  input  logic             dram_ack,
  output logic             dram_req,
  output logic             dram_we,
  output logic [OFF_W-1:0] dram_addr,
  output logic [1:0]       dram_be,
  output logic             dtack_n,
  output logic             berr_n,
  output logic             inv_valid,
  output logic [OFF_W-1:0] inv_addr,
  output logic             rd_accept,
  output logic             wr_done
);

  slv_state_e       state_q, state_d;
  logic             ds_prev_q;
  logic             ds_any;
  logic             start;
  logic             load;
  logic [OFF_W-1:0] addr_q;
  logic             we_q;
  logic [1:0]       be_q;
  logic             dtack_q, berr_q;
  logic             inv_q, inv_d;
  logic [OFF_W-1:0] inv_addr_q;

  assign ds_any = |ds_act;
  assign start  = ds_any && !ds_prev_q && as_act;
  assign load   = (state_q == ST_IDLE) && start && (kind == DEC_DRAM);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          case (kind)
            DEC_DRAM: state_d = ST_REQ;
            DEC_BERR: state_d = ST_BERR;
            default:  state_d = ST_SKIP;
          endcase
        end
      end
      ST_REQ: begin
        if (dram_ack) state_d = ST_ACK;
      end
      ST_ACK, ST_BERR, ST_SKIP: begin
        if (!ds_any) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign inv_d     = (state_q == ST_REQ) && dram_ack && we_q;
  assign rd_accept = load && write_n;
  assign wr_done   = (state_q == ST_ACK) && we_q && !ds_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ds_prev_q <= 1'b0;
      dtack_q   <= 1'b0;
      berr_q    <= 1'b0;
      inv_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ds_prev_q <= ds_any;
      dtack_q   <= (state_d == ST_ACK);
      berr_q    <= (state_d == ST_BERR);
      inv_q     <= inv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b0;
      be_q   <= '0;
    end else if (load) begin
      addr_q <= offs;
      we_q   <= !write_n;
      be_q   <= ds_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_addr_q <= '0;
    end else if (inv_d) begin
      inv_addr_q <= addr_q;
    end
  end

  assign dram_req  = (state_q == ST_REQ);
  assign dram_we   = we_q;
  assign dram_addr = addr_q;
  assign dram_be   = be_q;
  assign dtack_n   = !dtack_q;
  assign berr_n    = !berr_q;
  assign inv_valid = inv_q;
  assign inv_addr  = inv_addr_q;

endmodule

// File: rtl/vme_rmw_lock.sv
module vme_rmw_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic as_act,
  input  logic rd_accept,
  input  logic wr_done,
  input  logic cpu_req,
  output logic cpu_hold,
  output logic cpu_go
);

  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (rd_accept) begin
      hold_d = 1'b1;
    end else if (!as_act || wr_done) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign cpu_hold = hold_q;
  assign cpu_go   = cpu_req && !hold_q;

endmodule

// File: rtl/vme_a24_win_ctl.sv
module vme_a24_win_ctl
  import vme_win_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int WIN_W       = 22,
  parameter int DRAM_AW     = 21,
  parameter int SYNC_STAGES = 2,
  localparam int BASE_W     = ADDR_W - WIN_W,
  localparam int OFF_W      = WIN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic [BASE_W-1:0] win_base,
  input  logic [ADDR_W-1:1] vme_addr,
  input  logic [5:0]        vme_am,
  input  logic              vme_as_n,
  input  logic              vme_ds0_n,
  input  logic              vme_ds1_n,
  input  logic              vme_lword_n,
  input  logic              vme_write_n,
  output logic              vme_dtack_n,
  output logic              vme_berr_n,
  output logic              dram_req,
  output logic              dram_we,
  output logic [OFF_W-1:0]  dram_addr,
  output logic [1:0]        dram_be,
  input  logic              dram_ack,
  output logic              inv_valid,
  output logic [OFF_W-1:0]  inv_addr,
  input  logic              cpu_req,
  output logic              cpu_go,
  output logic              cpu_hold
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_int;
  logic [2:0]       strb_s;
  logic             as_act;
  logic [1:0]       ds_act;
  dec_kind_e        kind;
  logic [OFF_W-1:0] offs;
  logic             rd_accept;
  logic             wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  vme_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     ({!vme_as_n, !vme_ds1_n, !vme_ds0_n}),
    .q     (strb_s)
  );
  assign as_act = strb_s[2];
  assign ds_act = strb_s[1:0];

  vme_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .DRAM_AW(DRAM_AW)) u_dec (
    .addr     (vme_addr),
    .win_base (win_base),
    .am       (vme_am),
    .lword_n  (vme_lword_n),
    .ds_act   (ds_act),
    .slave_en (slave_en),
    .kind     (kind),
    .offs     (offs)
  );

  vme_slave_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .as_act    (as_act),
    .ds_act    (ds_act),
    .kind      (kind),
    .offs      (offs),
    .write_n   (vme_write_n),
    .dram_ack  (dram_ack),
    .dram_req  (dram_req),
    .dram_we   (dram_we),
    .dram_addr (dram_addr),
    .dram_be   (dram_be),
    .dtack_n   (vme_dtack_n),
    .berr_n    (vme_berr_n),
    .inv_valid (inv_valid),
    .inv_addr  (inv_addr),
    .rd_accept (rd_accept),
    .wr_done   (wr_done)
  );

  vme_rmw_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .as_act    (as_act),
    .rd_accept (rd_accept),
    .wr_done   (wr_done),
    .cpu_req   (cpu_req),
    .cpu_hold  (cpu_hold),
    .cpu_go    (cpu_go)
  );

endmodule

// File: rtl/vme_a24_win_ctl_chk.sv
module vme_a24_win_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic vme_dtack_n,
  input logic vme_berr_n,
  input logic vme_lword_n,
  input logic dram_req,
  input logic dram_ack,
  input logic inv_valid,
  input logic cpu_hold,
  input logic cpu_go
);

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!vme_dtack_n && !vme_berr_n)); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req && !dram_ack |=> dram_req); // R6

  AST_REQ_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |-> vme_berr_n); // R7

  AST_REQ_NO_D32: assert property (@(posedge clk) disable iff (!rst_n)
    dram_req |-> vme_lword_n); // R5

  AST_INV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid); // R9

  AST_INV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> $past(dram_ack)); // R9

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> !cpu_go); // R10

endmodule

bind vme_a24_win_ctl vme_a24_win_ctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vme_dtack_n (vme_dtack_n),
  .vme_berr_n  (vme_berr_n),
  .vme_lword_n (vme_lword_n),
  .dram_req    (dram_req),
  .dram_ack    (dram_ack),
  .inv_valid   (inv_valid),
  .cpu_hold    (cpu_hold),
  .cpu_go      (cpu_go)
);

// File: tb/vme_a24_win_ctl_tb_top.sv
module vme_a24_win_ctl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        slave_en;
  logic [1:0]  win_base;
  logic [23:1] vme_addr;
  logic [5:0]  vme_am;
  logic        vme_as_n, vme_ds0_n, vme_ds1_n, vme_lword_n, vme_write_n;
  logic        vme_dtack_n, vme_berr_n;
  logic        dram_req, dram_we;
  logic [20:0] dram_addr;
  logic [1:0]  dram_be;
  logic        dram_ack;
  logic        inv_valid;
  logic [20:0] inv_addr;
  logic        cpu_req, cpu_go, cpu_hold;

  int n_chk  = 0;
  int n_fail = 0;

  vme_a24_win_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .win_base(win_base),
    .vme_addr(vme_addr), .vme_am(vme_am), .vme_as_n(vme_as_n),
    .vme_ds0_n(vme_ds0_n), .vme_ds1_n(vme_ds1_n), .vme_lword_n(vme_lword_n),
    .vme_write_n(vme_write_n), .vme_dtack_n(vme_dtack_n), .vme_berr_n(vme_berr_n),
    .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_be(dram_be), .dram_ack(dram_ack), .inv_valid(inv_valid),
    .inv_addr(inv_addr), .cpu_req(cpu_req), .cpu_go(cpu_go), .cpu_hold(cpu_hold)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = !clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_go(input logic [23:0] a, input logic [5:0] am, input bit wr,
                        input bit d1, input bit d0, input bit lw);
    @(negedge clk);
    vme_addr    = a[23:1];
    vme_am      = am;
    vme_write_n = !wr;
    vme_lword_n = !lw;
    vme_as_n    = 1'b0;
    @(negedge clk);
    vme_ds1_n = !d1;
    vme_ds0_n = !d0;
  endtask

  task automatic ds_start(input logic [23:0] a, input bit wr, input bit d1, input bit d0);
    @(negedge clk);
    vme_addr    = a[23:1];
    vme_write_n = !wr;
    @(negedge clk);
    vme_ds1_n = !d1;
    vme_ds0_n = !d0;
  endtask

  task automatic serve(input string req, input bit we, input logic [23:0] a,
                       input logic [1:0] be);
    bit seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (dram_req) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(req, "dram_req seen", 32'(seen), 32'd1);
    chk(req, "dram_we", 32'(dram_we), 32'(we));
    chk(req, "dram_addr", 32'(dram_addr), 32'(a[21:1]));
    chk(req, "dram_be", 32'(dram_be), 32'(be));
    chk(req, "dtack before ack", 32'(vme_dtack_n), 32'd1);
    dram_ack = 1'b1;
    @(negedge clk);
    dram_ack = 1'b0;
    chk("R9", "inv_valid after ack", 32'(inv_valid), 32'(we));
    if (we) chk("R9", "inv_addr", 32'(inv_addr), 32'(a[21:1]));
    chk("R6", "dram_req dropped", 32'(dram_req), 32'd0);
    @(negedge clk);
    chk("R9", "inv_valid one cycle", 32'(inv_valid), 32'd0);
  endtask

  task automatic wait_resp(input string req, input int exp_kind);
    int  kind = 0;
    bit  req_seen = 0;
    for (int i = 0; i < 20; i++) begin
      if (dram_req) req_seen = 1;
      if (!vme_dtack_n) begin kind = 1; break; end
      if (!vme_berr_n)  begin kind = 2; break; end
      @(negedge clk);
    end
    chk(req, "response kind", 32'(kind), 32'(exp_kind));
    if (exp_kind == 2) chk(req, "no dram_req on BERR", 32'(req_seen), 32'd0);
  endtask

  task automatic ds_release(input string req);
    bit done = 0;
    @(negedge clk);
    vme_ds1_n = 1'b1;
    vme_ds0_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (vme_dtack_n && vme_berr_n) begin done = 1; break; end
    end
    chk(req, "DTACK/BERR released", 32'(done), 32'd1);
  endtask

  task automatic as_release;
    @(negedge clk);
    vme_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "dtack_n", 32'(vme_dtack_n), 32'd1);
    chk("R1", "berr_n", 32'(vme_berr_n), 32'd1);
    chk("R1", "dram_req", 32'(dram_req), 32'd0);
    chk("R1", "inv_valid", 32'(inv_valid), 32'd0);
    chk("R1", "cpu_hold", 32'(cpu_hold), 32'd0);
  endtask

  task automatic t_served(input string req, input logic [23:0] a, input logic [5:0] am,
                          input bit wr, input bit d1, input bit d0);
    bus_go(a, am, wr, d1, d0, 1'b0);
    serve(req, wr, a, {d1, d0});
    wait_resp("R6", 1);
    ds_release("R8");
    as_release();
  endtask

  task automatic t_berr(input logic [23:0] a, input bit wr);
    bus_go(a, 6'h39, wr, 1'b1, 1'b1, 1'b0);
    wait_resp("R7", 2);
    chk("R9", "no inv on BERR", 32'(inv_valid), 32'd0);
    ds_release("R8");
    as_release();
  endtask

  task automatic t_ignored(input string req, input logic [23:0] a, input logic [5:0] am,
                           input bit lw, input bit wr);
    bit any = 0;
    bus_go(a, am, wr, 1'b1, 1'b1, lw);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dram_req || !vme_dtack_n || !vme_berr_n || inv_valid) any = 1;
    end
    chk(req, "ignored access got no response", 32'(any), 32'd0);
    @(negedge clk);
    vme_ds1_n = 1'b1;
    vme_ds0_n = 1'b1;
    as_release();
  endtask

  task automatic t_rmw_write;
    bit cleared = 0;
    cpu_req = 1'b1;
    @(negedge clk);
    chk("R10", "cpu_go idle", 32'(cpu_go), 32'd1);
    bus_go(24'h400100, 6'h3D, 1'b0, 1'b1, 1'b1, 1'b0);
    serve("R10", 1'b0, 24'h400100, 2'b11);
    wait_resp("R10", 1);
    chk("R10", "cpu_hold after read", 32'(cpu_hold), 32'd1);
    chk("R10", "cpu_go stalled", 32'(cpu_go), 32'd0);
    ds_release("R8");
    repeat (4) @(negedge clk);
    chk("R10", "cpu_hold kept under AS", 32'(cpu_hold), 32'd1);
    ds_start(24'h400100, 1'b1, 1'b1, 1'b1);
    serve("R11", 1'b1, 24'h400100, 2'b11);
    wait_resp("R11", 1);
    chk("R11", "cpu_hold before write release", 32'(cpu_hold), 32'd1);
    @(negedge clk);
    vme_ds1_n = 1'b1;
    vme_ds0_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!cpu_hold) begin cleared = 1; break; end
    end
    chk("R11", "cpu_hold cleared by write", 32'(cleared), 32'd1);
    chk("R11", "cpu_go resumes", 32'(cpu_go), 32'd1);
    as_release();
    cpu_req = 1'b0;
  endtask

  task automatic t_rmw_as_drop;
    bit cleared = 0;
    bus_go(24'h4ABC00, 6'h39, 1'b0, 1'b0, 1'b1, 1'b0);
    serve("R12", 1'b0, 24'h4ABC00, 2'b01);
    wait_resp("R12", 1);
    ds_release("R8");
    repeat (3) @(negedge clk);
    chk("R12", "cpu_hold while AS held", 32'(cpu_hold), 32'd1);
    @(negedge clk);
    vme_as_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!cpu_hold) begin cleared = 1; break; end
    end
    chk("R12", "cpu_hold cleared by AS", 32'(cleared), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    slave_en    = 1'b0;
    win_base    = 2'd1;
    vme_addr    = '0;
    vme_am      = 6'h39;
    vme_as_n    = 1'b1;
    vme_ds0_n   = 1'b1;
    vme_ds1_n   = 1'b1;
    vme_lword_n = 1'b1;
    vme_write_n = 1'b1;
    dram_ack    = 1'b0;
    cpu_req     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();

    t_ignored("R2", 24'h400020, 6'h39, 1'b0, 1'b0);
    slave_en = 1'b1;

    t_served("R5", 24'h400010, 6'h39, 1'b0, 1'b1, 1'b1);
    t_served("R4", 24'h5FFFFE, 6'h3A, 1'b0, 1'b0, 1'b1);
    t_served("R5", 24'h412346, 6'h3D, 1'b1, 1'b1, 1'b0);
    t_served("R6", 24'h5ABCDE, 6'h3E, 1'b1, 1'b1, 1'b1);

    t_berr(24'h600100, 1'b0);
    t_berr(24'h7FFFF0, 1'b1);

    t_ignored("R4", 24'h400040, 6'h3B, 1'b0, 1'b0);
    t_ignored("R4", 24'h400040, 6'h3F, 1'b0, 1'b1);
    t_ignored("R4", 24'h400040, 6'h09, 1'b0, 1'b0);
    t_ignored("R5", 24'h400040, 6'h39, 1'b1, 1'b1);
    t_ignored("R3", 24'h200010, 6'h39, 1'b0, 1'b0);
    t_ignored("R3", 24'hC00010, 6'h3D, 1'b0, 1'b1);

    t_served("R3", 24'h400000, 6'h39, 1'b0, 1'b1, 1'b1);

    t_rmw_write();
    t_rmw_as_drop();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule